// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block is the device-side logic that decides what a flash part shows on its data bus while an internal program or erase is in progress. The command decoder and the program and erase engines live elsewhere. They tell this block whether a program is running, whether an erase is running or suspended, which sector is being erased, and whether the engine has exceeded its time limit. The array supplies the data that is read when no status is due. On every read cycle the block returns either that array data or a status byte. Two toggle bits in the status byte flip from one read to the next, which lets the host tell an active erase apart from a suspended one.

A command aimed at protected sectors gets special handling. The block runs a short status burst whose length is a fixed number of clock cycles, derived from the clock frequency, and then falls back to array reads. An open-drain ready/busy pull-down enable is raised whenever an operation is actually running.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `dout` equals `array_data` and `rb_pull` is 0.
- R2: With no program, erase, suspend or protected burst pending, every read returns `array_data` unchanged.
- R3: While a program, an unsuspended erase or a protected burst is in progress, each read returns status at any address. Bit 6 of that status starts at 0 after reset and inverts once for every completed read cycle.
- R4: While erase is suspended and no program runs, bit 6 holds its value across reads.
- R5: Bit 2 inverts after each read whose top SECW address bits equal `erase_sector`, while erase is running or suspended. Reads of other sectors leave it unchanged.
- R6: In erase-suspend-read, reads inside the suspended sector return status with bit 7 = 1. Reads outside it return `array_data`.
- R7: Status bit 7 is the complement of `pgm_d7` during a program, including a protected-program burst. It is 0 during an active erase or a protected-erase burst.
- R8: Status bit 5 reflects `time_fail`.
- R9: `cmd_done` with `cmd_erase`=1 and `tgt_prot`=1 starts a burst of CLK_MHZ*ERASE_PROT_NS/1000 cycles (225 by default) of toggling status with `rb_pull`=1. After the burst, reads return `array_data`.
- R10: `cmd_done` with `cmd_erase`=0 and `tgt_prot`=1 starts a burst of CLK_MHZ*PROG_PROT_NS/1000 cycles (31 by default) with the same behaviour as R9.
- R11: `rb_pull` is 1 during a program (including a program while erase is suspended), an unsuspended erase or a protected burst. It is 0 in erase-suspend-read and when idle.
- R12: Status bits 4, 3, 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_done | input | 1 | Pulse on the final write strobe of a command |
| cmd_erase | input | 1 | Command kind: 1 erase, 0 program |
| tgt_prot | input | 1 | All targeted sectors are protected |
| prog_busy | input | 1 | Program engine running |
| erase_busy | input | 1 | Erase engine holds an erase (active or suspended) |
| erase_susp | input | 1 | Erase suspended |
| erase_sector | input | SECW | Sector under erase |
| time_fail | input | 1 | Engine exceeded its time limit |
| pgm_d7 | input | 1 | Bit 7 of the datum being programmed |
| rd_stb | input | 1 | One read cycle (chip or output enable) |
| rd_addr | input | AW | Read address |
| array_data | input | 8 | Array read data |
| dout | output | 8 | Data bus value |
| rb_pull | output | 1 | Open-drain ready/busy pull-low enable |

## Verification
Reads are issued while the block is idle, during a program, during an active erase and during a program under suspension. The results show whether bit 6 follows the operation state rather than the address. Reads inside and outside the erase sector, both while the erase is active and while it is suspended, separate bit 2 from bit 6 and separate status reads from array reads. Protected erase and protected program commands are timed to the cycle at both ends of their bursts. This exposes any window length that is off by one.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int AW            = 21,
  parameter int SECW          = 6,
  parameter int CLK_MHZ       = 125,
  parameter int ERASE_PROT_NS = 1800,
  parameter int PROG_PROT_NS  = 250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_done,
  input  logic            cmd_erase,
  input  logic            tgt_prot,
  input  logic            prog_busy,
  input  logic            erase_busy,
  input  logic            erase_susp,
  input  logic [SECW-1:0] erase_sector,
  input  logic            time_fail,
  input  logic            pgm_d7,
  input  logic            rd_stb,
  input  logic [AW-1:0]   rd_addr,
  input  logic [7:0]      array_data,
  output logic [7:0]      dout,
  output logic            rb_pull
);
  localparam int EP_CYC = CLK_MHZ * ERASE_PROT_NS / 1000;
  localparam int PP_CYC = CLK_MHZ * PROG_PROT_NS / 1000;
  localparam int MAXC   = (EP_CYC > PP_CYC) ? EP_CYC : PP_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [CW-1:0] win_cnt;
  logic          win_erase;
  logic          t6, t2;

  wire win_on    = win_cnt != '0;
  wire sec_hit   = rd_addr[AW-1 -: SECW] == erase_sector;
  wire erase_run = erase_busy & ~erase_susp;
  wire run6      = prog_busy | erase_run | win_on;
  wire show_stat = run6 | (erase_susp & sec_hit);
  wire in_prog   = prog_busy | (win_on & ~win_erase);
  wire dq7       = in_prog ? ~pgm_d7 : erase_susp;

  assign dout    = show_stat ? {dq7, t6, time_fail, 2'b00, t2, 2'b00} : array_data;
  assign rb_pull = run6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      win_erase <= 1'b0;
      t6        <= 1'b0;
      t2        <= 1'b0;
    end else begin
      if (cmd_done && tgt_prot) begin
        win_cnt   <= cmd_erase ? CW'(EP_CYC) : CW'(PP_CYC);
        win_erase <= cmd_erase;
      end else if (win_on) begin
        win_cnt <= win_cnt - 1'b1;
      end
      if (rd_stb && run6)
        t6 <= ~t6;
      if (rd_stb && (erase_busy || erase_susp) && sec_hit)
        t2 <= ~t2;
    end
  end
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int AW   = 21,
  parameter int SECW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_busy,
  input logic          erase_busy,
  input logic          erase_susp,
  input logic          pgm_d7,
  input logic          rd_stb,
  input logic          win_on,
  input logic [7:0]    array_data,
  input logic [7:0]    dout,
  input logic          rb_pull
);
  a_r1_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_busy && !erase_busy && !erase_susp && !win_on) |-> dout == array_data);

  a_r3_prog_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && $past(prog_busy && rd_stb)) |-> dout[6] != $past(dout[6]));

  a_r7_prog_dq7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> dout[7] == ~pgm_d7);

  a_r11_prog_busy_pull: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> rb_pull);

  a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> (dout[4:3] == 2'b00 && dout[1:0] == 2'b00));
endmodule

bind flash_status_gen flash_status_chk #(.AW(AW), .SECW(SECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
  .erase_susp(erase_susp), .pgm_d7(pgm_d7), .rd_stb(rd_stb), .win_on(win_on),
  .array_data(array_data), .dout(dout), .rb_pull(rb_pull)
);

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
  localparam int AW = 21, SECW = 6;
  localparam int EPC = 225, PPC = 31;

  logic clk = 0, rst_n = 0;
  logic cmd_done = 0, cmd_erase = 0, tgt_prot = 0;
  logic prog_busy = 0, erase_busy = 0, erase_susp = 0;
  logic [SECW-1:0] erase_sector = '0;
  logic time_fail = 0, pgm_d7 = 0, rd_stb = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] array_data = 8'hA5;
  logic [7:0] dout;
  logic rb_pull;

  int total = 0, bad = 0;
  logic m6 = 0, m2 = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  flash_status_gen i_flash_status_gen (.*);

  function automatic logic [7:0] st(input logic d7);
    return {d7, m6, time_fail, 2'b00, m2, 2'b00};
  endfunction

  function automatic logic [AW-1:0] sa(input logic [SECW-1:0] s, input logic [AW-SECW-1:0] lo);
    return {s, lo};
  endfunction

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input bit f6, input bit f2, input string tag);
    @(posedge clk); #1;
    rd_addr = a; rd_stb = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_stb = 0;
    if (f6) m6 = ~m6;
    if (f2) m2 = ~m2;
  endtask

  always @(negedge clk) begin
    if (rd_stb) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++; $display("FAIL unexpected read dout=%h expected none", dout);
      end else begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (dout !== e) begin
          bad++; $display("FAIL %s dout=%h expected %h", t, dout, e);
        end
      end
    end
  end

  task automatic chk_rb(input logic e, input string tag);
    @(negedge clk);
    total++;
    if (rb_pull !== e) begin
      bad++; $display("FAIL %s rb_pull=%b expected %b", tag, rb_pull, e);
    end
  endtask

  task automatic cmd(input logic er);
    @(posedge clk); #1;
    cmd_done = 1; cmd_erase = er; tgt_prot = 1;
    @(posedge clk); #1;
    cmd_done = 0; tgt_prot = 0;
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (dout !== 8'hA5 || rb_pull !== 0) begin
      bad++; $display("FAIL R1 dout=%h rb=%b expected a5 0", dout, rb_pull);
    end
    rst_n = 1;
    rd(sa(6'd3, 15'h10), 8'hA5, 0, 0, "R2 idle read");
    array_data = 8'h3C;
    rd(sa(6'd9, 15'h0), 8'h3C, 0, 0, "R2 idle read 2");

    // program
    @(posedge clk); #1; prog_busy = 1; pgm_d7 = 1;
    chk_rb(1, "R11 program");
    rd(sa(6'd1, 15'h1), st(1'b0), 1, 0, "R3 R7 R12 program read");
    rd(sa(6'd40, 15'h7), st(1'b0), 1, 0, "R3 program read other addr");
    @(posedge clk); #1; pgm_d7 = 0;
    rd(sa(6'd2, 15'h2), st(1'b1), 1, 0, "R7 program dq7 complement");
    @(posedge clk); #1; prog_busy = 0;
    chk_rb(0, "R11 idle after program");
    rd(sa(6'd2, 15'h2), 8'h3C, 0, 0, "R2 after program");

    // active erase of sector 5
    @(posedge clk); #1; erase_busy = 1; erase_sector = 6'd5;
    chk_rb(1, "R11 erase");
    rd(sa(6'd5, 15'h4), st(1'b0), 1, 1, "R5 erase in-sector");
    rd(sa(6'd7, 15'h4), st(1'b0), 1, 0, "R5 erase other sector");
    rd(sa(6'd5, 15'h9), st(1'b0), 1, 1, "R5 erase in-sector again");
    @(posedge clk); #1; time_fail = 1;
    rd(sa(6'd5, 15'h9), st(1'b0), 1, 1, "R8 time fail");
    @(posedge clk); #1; time_fail = 0;

    // suspend
    @(posedge clk); #1; erase_susp = 1;
    chk_rb(0, "R11 suspend-read");
    rd(sa(6'd5, 15'h1), st(1'b1), 0, 1, "R4 R6 suspended sector");
    rd(sa(6'd5, 15'h2), st(1'b1), 0, 1, "R4 dq6 held");
    rd(sa(6'd8, 15'h2), 8'h3C, 0, 0, "R6 other sector array");

    // program during suspend
    @(posedge clk); #1; prog_busy = 1; pgm_d7 = 1;
    chk_rb(1, "R11 suspend-program");
    rd(sa(6'd8, 15'h3), st(1'b0), 1, 0, "R3 suspend-program toggle");
    rd(sa(6'd8, 15'h3), st(1'b0), 1, 0, "R3 suspend-program toggle 2");
    @(posedge clk); #1; prog_busy = 0; erase_susp = 0; erase_busy = 0;
    rd(sa(6'd5, 15'h3), 8'h3C, 0, 0, "R2 all done");

    // protected erase burst
    cmd(1'b1);
    rd(sa(6'd11, 15'h0), st(1'b0), 1, 0, "R9 burst status");
    repeat (EPC - 3) @(posedge clk);
    chk_rb(1, "R9 last burst cycle");
    @(posedge clk);
    chk_rb(0, "R9 burst ended");
    rd(sa(6'd11, 15'h0), 8'h3C, 0, 0, "R9 array after burst");

    // protected program burst
    pgm_d7 = 0;
    cmd(1'b0);
    rd(sa(6'd12, 15'h0), st(1'b1), 1, 0, "R10 burst status");
    repeat (PPC - 3) @(posedge clk);
    chk_rb(1, "R10 last burst cycle");
    @(posedge clk);
    chk_rb(0, "R10 burst ended");
    rd(sa(6'd12, 15'h0), 8'h3C, 0, 0, "R10 array after burst");

    finish_run();
  end
endmodule